// File: doc/BRIEF.md
# Hot-Plug Slot Controller

This block holds the hot-plug control and status logic for a single downstream expansion slot. It watches three physical sensors: an attention push-button, a card-presence detector and a retention-latch sensor. It turns their debounced transitions into sticky event flags that software clears by writing 1. When the interrupt enable is set, any pending flag drives an interrupt request. Software reads the status register to learn what happened, such as a card arriving, a card leaving, the latch moving or the button being pressed.

Software drives the slot through a control register. The register holds the power indicator, the attention indicator (on, off or blinking from a prescaled clock), the slot power switch and an electromechanical interlock that holds the card in place. A capabilities register advertises hot-plug support, surprise-removal capability, whether a power controller is fitted, and the physical slot number. Two safety actions happen without software. When a power controller is fitted, slot power is cut as soon as the latch opens. On a surprise-removal-capable slot, slot power is also cut when the card disappears.

Top module: `hpc_slot_ctrl`

## Requirements
- R1: Address 0 reads the capabilities word. Bit 0 is 1 (hot-plug supported). Bit 1 equals SURPRISE_OK. Bit 2 equals HAS_PWR_CTRL. Bits 15:8 carry SLOT_NUM. All other bits are 0. Writes to address 0 have no effect, and address 3 reads 0.
- R2: After reset the control register (address 1) reads 0x001E. That is, the interrupt enable is 0, both indicator fields are 11 (off), slot power is off and the interlock is released. The status event bits read 0, and slot_pwr_en, pwr_led, attn_led, interlock_en and irq are all 0.
- R3: Each sensor input passes through a two-flop synchronizer and a debounce counter. A level must hold for DEB_CYCLES consecutive clocks before it is accepted. A button pulse shorter than that leaves status bit 0 clear. An accepted press (0 to 1) sets status bit 0, and the release sets nothing.
- R4: Status bit 4 shows the debounced presence level, and any accepted presence change sets status bit 2. Status bit 5 shows the debounced latch level (1 = open), and any accepted latch change sets status bit 1.
- R5: Status event bits 2:0 are sticky. Writing status (address 2) with a 1 in a bit clears that bit, and a 0 leaves it unchanged. A new event in the same cycle wins over the clear.
- R6: irq is 1 exactly when the interrupt enable (control bit 0) is 1 and at least one event bit is pending. Events latch even while the enable is 0. Clearing one event while another is pending keeps irq at 1.
- R7: The indicator fields are control bits 2:1 (power) and 4:3 (attention). The code 01 drives the LED to 1 and 11 drives it to 0. The code 10 makes the LED toggle once every BLINK_DIV clocks. Writing 00 leaves that field unchanged.
- R8: With HAS_PWR_CTRL=1, slot_pwr_en follows control bit 5. An accepted latch opening clears bit 5 and removes power. A write of 1 to bit 5 while the latch is open is ignored. With HAS_PWR_CTRL=0, slot_pwr_en is held at 1.
- R9: With SURPRISE_OK=1, an accepted loss of presence clears control bit 5 and removes slot power. With SURPRISE_OK=0, power stays under software control.
- R10: Control bit 6 drives interlock_en directly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| reg_addr | input | 2 | Register select: 0 capabilities, 1 control, 2 status |
| reg_wr | input | 1 | Write strobe for the selected register |
| reg_wdata | input | 7 | Write data (control bits 6:0, status clear mask bits 2:0) |
| reg_rdata | output | 16 | Read data of the selected register |
| btn_in | input | 1 | Raw attention button, 1 = pressed |
| prsnt_in | input | 1 | Raw presence detect, 1 = card present |
| latch_open_in | input | 1 | Raw retention-latch sensor, 1 = open |
| slot_pwr_en | output | 1 | Slot power switch enable |
| pwr_led | output | 1 | Power indicator drive |
| attn_led | output | 1 | Attention indicator drive |
| interlock_en | output | 1 | Electromechanical interlock drive |
| irq | output | 1 | Hot-plug interrupt request |

## Verification
The hardest states to reach from the ports are an automatic power cut arriving while software also holds the power bit on, and irq staying high after one flag is cleared. For these cases the bench first enables power and keeps it enabled, then opens the latch and tries to re-enable power while the latch is still open. Separately, it stacks a presence event on top of a pending button event before clearing them one at a time. The debounce filter is checked by a glitch shorter than DEB_CYCLES and by a press longer than it. Blink timing is checked by counting LED transitions over a window several blink periods long.

// File: rtl/hpc_pkg.sv
package hpc_pkg;
  localparam int NUM_IN  = 3;
  localparam int IN_BTN  = 0;
  localparam int IN_PRS  = 1;
  localparam int IN_LAT  = 2;
  localparam int RD_W    = 16;
  localparam int WR_W    = 7;
  localparam int EV_W    = 3;
  localparam logic [1:0] ADDR_CAP  = 2'd0;
  localparam logic [1:0] ADDR_CTRL = 2'd1;
  localparam logic [1:0] ADDR_STAT = 2'd2;

  typedef enum logic [1:0] {
    IND_RSVD  = 2'b00,
    IND_ON    = 2'b01,
    IND_BLINK = 2'b10,
    IND_OFF   = 2'b11
  } ind_mode_e;
endpackage

// File: rtl/hpc_debounce.sv
module hpc_debounce #(
  parameter int DEB_CYCLES = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic raw_in,
  output logic level,
  output logic changed
);
  localparam int CW = (DEB_CYCLES > 1) ? $clog2(DEB_CYCLES) : 1;
  localparam logic [CW-1:0] CNT_LAST = CW'(DEB_CYCLES - 1);

  logic sync1_q, sync2_q;
  logic [CW-1:0] cnt_q, cnt_d;
  logic lvl_q, lvl_d, chg_q, chg_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync1_q <= 1'b0;
      sync2_q <= 1'b0;
    end else begin
      sync1_q <= raw_in;
      sync2_q <= sync1_q;
    end
  end

  always_comb begin
    cnt_d = cnt_q;
    lvl_d = lvl_q;
    chg_d = 1'b0;
    if (sync2_q == lvl_q) begin
      cnt_d = '0;
    end else if (cnt_q == CNT_LAST) begin
      cnt_d = '0;
      lvl_d = sync2_q;
      chg_d = 1'b1;
    end else begin
      cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      lvl_q <= 1'b0;
      chg_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      lvl_q <= lvl_d;
      chg_q <= chg_d;
    end
  end

  assign level   = lvl_q;
  assign changed = chg_q;

  AST_DEB_AGREE: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(lvl_q) |-> ($past(sync2_q) == lvl_q)); // R3
endmodule

// File: rtl/hpc_blink.sv
module hpc_blink #(
  parameter int BLINK_DIV = 25_000_000
) (
  input  logic clk,
  input  logic rst_n,
  output logic phase
);
  localparam int CW = (BLINK_DIV > 1) ? $clog2(BLINK_DIV) : 1;
  localparam logic [CW-1:0] CNT_LAST = CW'(BLINK_DIV - 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic ph_q, ph_d;

  always_comb begin
    cnt_d = cnt_q + 1'b1;
    ph_d  = ph_q;
    if (cnt_q == CNT_LAST) begin
      cnt_d = '0;
      ph_d  = ~ph_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      ph_q  <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      ph_q  <= ph_d;
    end
  end

  assign phase = ph_q;

  AST_PHASE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q != CNT_LAST) |=> $stable(ph_q)); // R7
endmodule

// File: rtl/hpc_indicator.sv
module hpc_indicator
  import hpc_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  ind_mode_e  mode,
  input  logic       phase,
  output logic       led
);
  logic led_q, led_d;

  always_comb begin
    case (mode)
      IND_ON:    led_d = 1'b1;
      IND_BLINK: led_d = phase;
      default:   led_d = 1'b0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) led_q <= 1'b0;
    else        led_q <= led_d;
  end

  assign led = led_q;

  AST_LED_ON: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == IND_ON) |=> led_q); // R7
endmodule

// File: rtl/hpc_slot_ctrl.sv
module hpc_slot_ctrl
  import hpc_pkg::*;
#(
  parameter int          DEB_CYCLES   = 16,
  parameter int          BLINK_DIV    = 25_000_000,
  parameter logic [7:0]  SLOT_NUM     = 8'd1,
  parameter bit          SURPRISE_OK  = 1'b1,
  parameter bit          HAS_PWR_CTRL = 1'b1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [1:0]      reg_addr,
  input  logic            reg_wr,
  input  logic [WR_W-1:0] reg_wdata,
  output logic [RD_W-1:0] reg_rdata,
  input  logic            btn_in,
  input  logic            prsnt_in,
  input  logic            latch_open_in,
  output logic            slot_pwr_en,
  output logic            pwr_led,
  output logic            attn_led,
  output logic            interlock_en,
  output logic            irq
);
  localparam logic [RD_W-1:0] CAP_WORD =
    {SLOT_NUM, 5'd0, HAS_PWR_CTRL, SURPRISE_OK, 1'b1};

  // reset: asserted asynchronously, released after two clocks
  logic rs1_q, rs2_q, srst_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rs1_q <= 1'b0;
      rs2_q <= 1'b0;
    end else begin
      rs1_q <= 1'b1;
      rs2_q <= rs1_q;
    end
  end
  assign srst_n = rs2_q;

  // sensor conditioning
  logic [NUM_IN-1:0] raw_in, lvl, chg;
  assign raw_in = {latch_open_in, prsnt_in, btn_in};

  for (genvar g = 0; g < NUM_IN; g++) begin : g_deb
    hpc_debounce #(.DEB_CYCLES(DEB_CYCLES)) u_deb (
      .clk     (clk),
      .rst_n   (srst_n),
      .raw_in  (raw_in[g]),
      .level   (lvl[g]),
      .changed (chg[g])
    );
  end

  logic btn_press, lat_open_ev, prs_lost;
  logic [EV_W-1:0] new_ev;
  assign btn_press   = chg[IN_BTN] & lvl[IN_BTN];
  assign lat_open_ev = chg[IN_LAT] & lvl[IN_LAT];
  assign prs_lost    = chg[IN_PRS] & ~lvl[IN_PRS];
  assign new_ev      = {chg[IN_PRS], chg[IN_LAT], btn_press};

  // register access decode
  logic ctrl_wr, stat_wr;
  assign ctrl_wr = reg_wr && (reg_addr == ADDR_CTRL);
  assign stat_wr = reg_wr && (reg_addr == ADDR_STAT);

  // control and status state
  logic            int_en_q, int_en_d;
  ind_mode_e       pind_q, pind_d, aind_q, aind_d;
  logic            pwr_q, pwr_d;
  logic            lock_q, lock_d;
  logic [EV_W-1:0] ev_q, ev_d, clr_mask;

  assign clr_mask = stat_wr ? reg_wdata[EV_W-1:0] : '0;

  always_comb begin
    int_en_d = int_en_q;
    pind_d   = pind_q;
    aind_d   = aind_q;
    pwr_d    = pwr_q;
    lock_d   = lock_q;
    if (ctrl_wr) begin
      int_en_d = reg_wdata[0];
      if (reg_wdata[2:1] != IND_RSVD) pind_d = ind_mode_e'(reg_wdata[2:1]);
      if (reg_wdata[4:3] != IND_RSVD) aind_d = ind_mode_e'(reg_wdata[4:3]);
      pwr_d  = reg_wdata[5] & ~lvl[IN_LAT];
      lock_d = reg_wdata[6];
    end
    if (HAS_PWR_CTRL && lat_open_ev) pwr_d = 1'b0;
    if (SURPRISE_OK && prs_lost)     pwr_d = 1'b0;
  end

  always_comb begin
    ev_d = (ev_q & ~clr_mask) | new_ev;
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      int_en_q <= 1'b0;
      pind_q   <= IND_OFF;
      aind_q   <= IND_OFF;
      pwr_q    <= 1'b0;
      lock_q   <= 1'b0;
      ev_q     <= '0;
    end else begin
      int_en_q <= int_en_d;
      pind_q   <= pind_d;
      aind_q   <= aind_d;
      pwr_q    <= pwr_d;
      lock_q   <= lock_d;
      ev_q     <= ev_d;
    end
  end

  // indicators
  logic phase;
  ind_mode_e ind_mode [2];
  logic [1:0] led_drv;
  assign ind_mode[0] = pind_q;
  assign ind_mode[1] = aind_q;

  hpc_blink #(.BLINK_DIV(BLINK_DIV)) u_blink (
    .clk   (clk),
    .rst_n (srst_n),
    .phase (phase)
  );

  for (genvar i = 0; i < 2; i++) begin : g_ind
    hpc_indicator u_ind (
      .clk   (clk),
      .rst_n (srst_n),
      .mode  (ind_mode[i]),
      .phase (phase),
      .led   (led_drv[i])
    );
  end

  assign pwr_led      = led_drv[0];
  assign attn_led     = led_drv[1];
  assign slot_pwr_en  = HAS_PWR_CTRL ? pwr_q : 1'b1;
  assign interlock_en = lock_q;
  assign irq          = int_en_q & (|ev_q);

  // read mux
  always_comb begin
    case (reg_addr)
      ADDR_CAP:  reg_rdata = CAP_WORD;
      ADDR_CTRL: reg_rdata = {9'd0, lock_q, pwr_q, aind_q, pind_q, int_en_q};
      ADDR_STAT: reg_rdata = {10'd0, lvl[IN_LAT], lvl[IN_PRS], 1'b0, ev_q};
      default:   reg_rdata = '0;
    endcase
  end

  AST_LATCH_CUTS_PWR: assert property (@(posedge clk) disable iff (!srst_n)
    (HAS_PWR_CTRL && lat_open_ev) |=> !slot_pwr_en); // R8
  AST_SURPRISE_CUT: assert property (@(posedge clk) disable iff (!srst_n)
    (SURPRISE_OK && HAS_PWR_CTRL && prs_lost) |=> !slot_pwr_en); // R9
  AST_EV_STICKY: assert property (@(posedge clk) disable iff (!srst_n)
    !stat_wr |=> ((ev_q & $past(ev_q)) == $past(ev_q))); // R5
  AST_IRQ_ON_EVENT: assert property (@(posedge clk) disable iff (!srst_n)
    (int_en_q && (new_ev != '0) && !ctrl_wr) |=> irq); // R6
endmodule

// File: tb/hpc_slot_ctrl_tb_top.sv
module hpc_slot_ctrl_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int DEB  = 4;
  localparam int BDIV = 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  reg_addr = 2'd0;
  logic        reg_wr = 1'b0;
  logic [6:0]  reg_wdata = 7'd0;
  logic [15:0] reg_rdata;
  logic        btn_in = 1'b0, prsnt_in = 1'b0, latch_open_in = 1'b0;
  logic        slot_pwr_en, pwr_led, attn_led, interlock_en, irq;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  hpc_slot_ctrl #(
    .DEB_CYCLES(DEB), .BLINK_DIV(BDIV), .SLOT_NUM(8'h2A),
    .SURPRISE_OK(1'b1), .HAS_PWR_CTRL(1'b1)
  ) dut_i (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .btn_in(btn_in),
    .prsnt_in(prsnt_in), .latch_open_in(latch_open_in),
    .slot_pwr_en(slot_pwr_en), .pwr_led(pwr_led), .attn_led(attn_led),
    .interlock_en(interlock_en), .irq(irq)
  );

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=0x%04h expected=0x%04h", req, act, exp);
    end
  endtask

  task automatic rd(input logic [1:0] a, output logic [15:0] d);
    @(negedge clk);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic wr(input logic [1:0] a, input logic [6:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  function automatic logic [6:0] cw(input logic ie, input logic [1:0] pi,
                                    input logic [1:0] ai, input logic pw, input logic lk);
    return {lk, pw, ai, pi, ie};
  endfunction

  task automatic settle();
    repeat (DEB + 8) @(negedge clk);
  endtask

  task automatic t_reset();
    logic [15:0] d;
    rd(2'd0, d); chk("R1 capabilities", d, 16'h2A07);
    wr(2'd0, 7'h7F);
    rd(2'd0, d); chk("R1 capabilities after write", d, 16'h2A07);
    rd(2'd3, d); chk("R1 unused address", d, 16'h0000);
    rd(2'd1, d); chk("R2 control reset", d, 16'h001E);
    rd(2'd2, d); chk("R2 status reset", d, 16'h0000);
    chk("R2 outputs reset", {11'd0, slot_pwr_en, pwr_led, attn_led, interlock_en, irq}, 16'h0);
  endtask

  task automatic t_button();
    logic [15:0] d;
    @(negedge clk); btn_in = 1'b1;
    repeat (2) @(negedge clk); btn_in = 1'b0;
    settle();
    rd(2'd2, d); chk("R3 short glitch ignored", d, 16'h0000);
    @(negedge clk); btn_in = 1'b1;
    settle();
    rd(2'd2, d); chk("R3 press latched", d, 16'h0001);
    chk("R6 irq masked when disabled", {15'd0, irq}, 16'h0);
    @(negedge clk); btn_in = 1'b0;
    settle();
    rd(2'd2, d); chk("R3 release sets nothing", d, 16'h0001);
  endtask

  task automatic t_w1c();
    logic [15:0] d;
    wr(2'd2, 7'h00);
    rd(2'd2, d); chk("R5 write 0 keeps event", d, 16'h0001);
    wr(2'd1, cw(1'b1, 2'b11, 2'b11, 1'b0, 1'b0));
    @(negedge clk); chk("R6 irq after enable", {15'd0, irq}, 16'h1);
  endtask

  task automatic t_irq();
    logic [15:0] d;
    @(negedge clk); prsnt_in = 1'b1;
    settle();
    rd(2'd2, d); chk("R4 presence event and level", d, 16'h0015);
    wr(2'd2, 7'h01);
    rd(2'd2, d); chk("R5 clear one bit only", d, 16'h0014);
    chk("R6 irq stays with other event pending", {15'd0, irq}, 16'h1);
    wr(2'd2, 7'h04);
    @(negedge clk); chk("R6 irq drops when none pending", {15'd0, irq}, 16'h0);
  endtask

  task automatic t_indicators();
    logic [15:0] d;
    logic prev;
    int tog;
    wr(2'd1, cw(1'b1, 2'b01, 2'b11, 1'b0, 1'b0));
    @(negedge clk);
    chk("R7 power indicator on", {14'd0, pwr_led, attn_led}, 16'h2);
    wr(2'd1, cw(1'b1, 2'b01, 2'b10, 1'b0, 1'b0));
    repeat (3) @(negedge clk);
    prev = attn_led; tog = 0;
    for (int i = 0; i < 5 * BDIV; i++) begin
      @(negedge clk);
      if (attn_led != prev) tog++;
      prev = attn_led;
    end
    chk("R7 blink toggle count", 16'(tog), 16'd5);
    wr(2'd1, cw(1'b1, 2'b00, 2'b00, 1'b0, 1'b0));
    rd(2'd1, d); chk("R7 code 00 leaves fields", d, 16'(cw(1'b1, 2'b01, 2'b10, 1'b0, 1'b0)));
    wr(2'd1, cw(1'b1, 2'b01, 2'b11, 1'b0, 1'b0));
    @(negedge clk);
    chk("R7 attention off", {15'd0, attn_led}, 16'h0);
  endtask

  task automatic t_power();
    logic [15:0] d;
    wr(2'd1, cw(1'b0, 2'b01, 2'b11, 1'b1, 1'b1));
    @(negedge clk);
    chk("R8 power on", {15'd0, slot_pwr_en}, 16'h1);
    chk("R10 interlock on", {15'd0, interlock_en}, 16'h1);
    @(negedge clk); latch_open_in = 1'b1;
    settle();
    chk("R8 latch open cuts power", {15'd0, slot_pwr_en}, 16'h0);
    rd(2'd2, d); chk("R4 latch event and level", d, 16'h0032);
    wr(2'd1, cw(1'b0, 2'b01, 2'b11, 1'b1, 1'b0));
    @(negedge clk);
    chk("R8 power write ignored while open", {15'd0, slot_pwr_en}, 16'h0);
    chk("R10 interlock released", {15'd0, interlock_en}, 16'h0);
    @(negedge clk); latch_open_in = 1'b0;
    settle();
    wr(2'd2, 7'h07);
    rd(2'd2, d); chk("R5 all cleared", d, 16'h0010);
    wr(2'd1, cw(1'b0, 2'b01, 2'b11, 1'b1, 1'b0));
    @(negedge clk);
    chk("R8 power on after latch closed", {15'd0, slot_pwr_en}, 16'h1);
  endtask

  task automatic t_surprise();
    logic [15:0] d;
    @(negedge clk); prsnt_in = 1'b0;
    settle();
    chk("R9 surprise removal cuts power", {15'd0, slot_pwr_en}, 16'h0);
    rd(2'd2, d); chk("R4 removal event", d, 16'h0004);
    rd(2'd1, d); chk("R9 power bit cleared", {15'd0, d[5]}, 16'h0);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin : main
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    t_reset();
    t_button();
    t_w1c();
    t_irq();
    t_indicators();
    t_power();
    t_surprise();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule